// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit logical address into a physical address when a translation is missing. It walks a page table that has two levels and lives in memory. The logical address carries a 10-bit byte offset within a 1 KiB page. Above the offset sit a 10-bit inner index and, in the top 12 bits, an outer index. The walker first reads the outer-table entry that the outer index selects. That entry points to an inner table. The walker then reads the inner-table entry that the inner index selects, and returns the frame number in that entry joined with the original offset.

A walk can end in a fault instead of a result. This happens when the outer index is not below the configured table length, or when either entry has its valid bit clear. Each fault reports a code that tells which check failed.

The requester offers one address at a time through a valid/ready request port. The walker then issues single-word reads on a plain request/response memory port, one read at a time. The result, or the fault, stays on a valid/ready result port until the requester takes it. The table base and the table length come from configuration inputs, and both are sampled when the request is accepted.

Top module: `pt_walker`

## Requirements
- R1: The logical address splits as follows: bits 31:20 are the outer index, bits 19:10 are the inner index, and bits 9:0 are the page offset. The offset appears unchanged in bits 9:0 of a successful result.
- R2: The first memory read of a walk targets the byte address `cfg_base + outer_index*4`, using the base sampled when the request was accepted.
- R3: The second read is issued only after the outer response has arrived with entry bit 0 set. It targets `{outer_entry[31:10], 10'b0} + inner_index*4`.
- R4: A walk whose two entries are both valid returns `res_paddr = {inner_entry[31:10], offset}`, with `res_fault = 0` and `res_cause = 0`. Entry bits 9:1 are ignored.
- R5: If the outer index is greater than or equal to `cfg_len`, the walk faults with `res_cause = 1` and issues no memory read. The result is valid in the cycle after acceptance.
- R6: An outer entry with bit 0 clear faults with `res_cause = 2` after exactly one read.
- R7: An inner entry with bit 0 clear faults with `res_cause = 3` after two reads.
- R8: Only one walk runs at a time. `req_ready` is high only when no walk is in flight. `busy` rises at acceptance and stays high until the result is taken. Requests offered while busy are not accepted.
- R9: While `res_ready` is low, `res_valid`, `res_paddr`, `res_fault` and `res_cause` hold steady. One cycle after the result is taken, `res_valid` is low and `req_ready` is high. Every fault reports `res_paddr = 0`.
- R10: A read request holds its valid and its address steady until `mem_req_ready` is seen. No new read is requested while a response is still outstanding.
- R11: Counted in clock edges after the accepting edge, with S stall cycles per read and a response latency of L cycles, a full walk takes 2*(1+S+L) edges and an outer-invalid fault takes 1+S+L edges.
- R12: During reset, `req_ready` is high and `busy`, `mem_req_valid` and `res_valid` are low.
- R13: Changing `cfg_base` after acceptance has no effect on the walk in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Logical address to translate |
| cfg_base | input | 32 | Byte address of the outer table |
| cfg_len | input | 13 | Number of outer-table entries |
| mem_req_valid | output | 1 | Memory read requested |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry; bit 0 valid, bits 31:10 pointer or frame |
| res_valid | output | 1 | Result presented |
| res_ready | input | 1 | Requester takes the result |
| res_paddr | output | 32 | Physical address, zero on fault |
| res_fault | output | 1 | Walk ended in a fault |
| res_cause | output | 2 | 0 none, 1 length, 2 outer invalid, 3 inner invalid |
| busy | output | 1 | Walk in flight or result waiting |

## Verification
Every result is due a fixed number of edges after the accepting edge. The count is zero for a length fault, 1+S+L for an outer-invalid fault, and 2*(1+S+L) for a completed walk. The bench counts falling edges from acceptance until `res_valid` is seen and compares that count with the formula for the scenario's stall and latency settings. The bench's memory model answers each read on the L-th falling edge after the read handshake and checks each request address, including during stalls. Hold and release of the result are sampled on falling edges before and after `res_ready` is raised.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W_DEF       = 32;
    localparam int OFF_W_DEF      = 10;
    localparam int INNER_W_DEF    = 10;
    localparam int PTE_BYTES_LOG2 = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_OUTER,
        ST_WT_OUTER,
        ST_RD_INNER,
        ST_WT_INNER,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_RANGE = 2'd1,
        FLT_OUTER = 2'd2,
        FLT_INNER = 2'd3
    } fault_e;

    // Map a returned entry's valid bit to a fault code for the level it came from.
    function automatic fault_e classify_rsp(input logic is_outer, input logic present);
        if (present)
            return FLT_NONE;
        return is_outer ? FLT_OUTER : FLT_INNER;
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int VA_W    = VA_W_DEF,
    parameter int OFF_W   = OFF_W_DEF,
    parameter int INNER_W = INNER_W_DEF
) (
    input  logic [VA_W-1:0]       va_q,
    input  logic [VA_W-1:0]       base_q,
    input  logic [VA_W-OFF_W-1:0] ptr_q,
    input  logic                  sel_inner,
    output logic [OFF_W-1:0]      offset,
    output logic [VA_W-1:0]       rd_addr
);
    localparam int OUTER_W = VA_W - OFF_W - INNER_W;

    typedef struct packed {
        logic [OUTER_W-1:0] outer;
        logic [INNER_W-1:0] inner;
        logic [OFF_W-1:0]   off;
    } va_fields_t;

    va_fields_t      f;
    logic [VA_W-1:0] outer_addr;
    logic [VA_W-1:0] inner_addr;

    assign f = va_fields_t'(va_q);

    assign outer_addr = base_q
                      + ({{(VA_W-OUTER_W){1'b0}}, f.outer} << PTE_BYTES_LOG2);
    assign inner_addr = {ptr_q, {OFF_W{1'b0}}}
                      + ({{(VA_W-INNER_W){1'b0}}, f.inner} << PTE_BYTES_LOG2);

    assign rd_addr = sel_inner ? inner_addr : outer_addr;
    assign offset  = f.off;

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_fire,
    input  logic        range_bad,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  logic        rsp_present,
    input  logic        res_fire,
    output walk_state_e state_q,
    output logic        mem_req_valid,
    output logic        sel_inner,
    output logic        ptr_load,
    output logic        res_set,
    output fault_e      res_cause_set,
    output logic        idle
);
    walk_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d       = state_q;
        mem_req_valid = 1'b0;
        sel_inner     = 1'b0;
        ptr_load      = 1'b0;
        res_set       = 1'b0;
        res_cause_set = FLT_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (req_fire) begin
                    if (range_bad) begin
                        res_set       = 1'b1;
                        res_cause_set = FLT_RANGE;
                        state_d       = ST_FAULT;
                    end else begin
                        state_d = ST_RD_OUTER;
                    end
                end
            end
            ST_RD_OUTER: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready)
                    state_d = ST_WT_OUTER;
            end
            ST_WT_OUTER: begin
                if (mem_rsp_valid) begin
                    if (rsp_present) begin
                        ptr_load = 1'b1;
                        state_d  = ST_RD_INNER;
                    end else begin
                        res_set       = 1'b1;
                        res_cause_set = classify_rsp(1'b1, 1'b0);
                        state_d       = ST_FAULT;
                    end
                end
            end
            ST_RD_INNER: begin
                mem_req_valid = 1'b1;
                sel_inner     = 1'b1;
                if (mem_req_ready)
                    state_d = ST_WT_INNER;
            end
            ST_WT_INNER: begin
                if (mem_rsp_valid) begin
                    res_set       = 1'b1;
                    res_cause_set = classify_rsp(1'b0, rsp_present);
                    state_d       = rsp_present ? ST_DONE : ST_FAULT;
                end
            end
            ST_DONE, ST_FAULT: begin
                if (res_fire)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign idle = (state_q == ST_IDLE);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && sel_inner == $past(sel_inner))); // R10

    AST_ONE_WALK: assert property (@(posedge clk) disable iff (rst)
        req_fire |=> !idle); // R8

endmodule

// File: rtl/ptw_result.sv
module ptw_result
    import ptw_pkg::*;
#(
    parameter int PA_W = VA_W_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set,
    input  fault_e          set_cause,
    input  logic [PA_W-1:0] set_paddr,
    input  logic            ready,
    output logic            valid,
    output logic [PA_W-1:0] paddr,
    output fault_e          cause
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            paddr <= '0;
            cause <= FLT_NONE;
        end else if (set) begin
            valid <= 1'b1;
            paddr <= set_paddr;
            cause <= set_cause;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

    AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(paddr) && $stable(cause))); // R9

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int VA_W    = VA_W_DEF,
    parameter int OFF_W   = OFF_W_DEF,
    parameter int INNER_W = INNER_W_DEF
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic [VA_W-1:0]                req_vaddr,
    input  logic [VA_W-1:0]                cfg_base,
    input  logic [VA_W-OFF_W-INNER_W:0]    cfg_len,
    output logic                           mem_req_valid,
    input  logic                           mem_req_ready,
    output logic [VA_W-1:0]                mem_req_addr,
    input  logic                           mem_rsp_valid,
    input  logic [VA_W-1:0]                mem_rsp_data,
    output logic                           res_valid,
    input  logic                           res_ready,
    output logic [VA_W-1:0]                res_paddr,
    output logic                           res_fault,
    output logic [1:0]                     res_cause,
    output logic                           busy
);
    localparam int OUTER_W = VA_W - OFF_W - INNER_W;
    localparam int PTR_W   = VA_W - OFF_W;

    logic [VA_W-1:0]  va_q;
    logic [VA_W-1:0]  base_q;
    logic [PTR_W-1:0] ptr_q;
    logic [OFF_W-1:0] offset;
    logic [OUTER_W:0] req_outer_ext;
    logic             range_bad;
    logic             req_fire;
    logic             res_fire;
    logic             idle;
    logic             sel_inner;
    logic             ptr_load;
    logic             res_set;
    fault_e           res_cause_set;
    fault_e           cause_q;
    walk_state_e      walk_state;
    logic [VA_W-1:0]  set_paddr;
    logic             unused_entry_bits;

    assign req_outer_ext = {1'b0, req_vaddr[VA_W-1 -: OUTER_W]};
    assign range_bad     = (req_outer_ext >= cfg_len);
    assign req_fire      = req_valid && idle;
    assign res_fire      = res_valid && res_ready;
    assign req_ready     = idle;
    assign busy          = !idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q   <= '0;
            base_q <= '0;
            ptr_q  <= '0;
        end else begin
            if (req_fire) begin
                va_q   <= req_vaddr;
                base_q <= cfg_base;
            end
            if (ptr_load)
                ptr_q <= mem_rsp_data[VA_W-1:OFF_W];
        end
    end

    ptw_addr_gen #(
        .VA_W    (VA_W),
        .OFF_W   (OFF_W),
        .INNER_W (INNER_W)
    ) u_addr (
        .va_q      (va_q),
        .base_q    (base_q),
        .ptr_q     (ptr_q),
        .sel_inner (sel_inner),
        .offset    (offset),
        .rd_addr   (mem_req_addr)
    );

    ptw_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_fire      (req_fire),
        .range_bad     (range_bad),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .rsp_present   (mem_rsp_data[0]),
        .res_fire      (res_fire),
        .state_q       (walk_state),
        .mem_req_valid (mem_req_valid),
        .sel_inner     (sel_inner),
        .ptr_load      (ptr_load),
        .res_set       (res_set),
        .res_cause_set (res_cause_set),
        .idle          (idle)
    );

    assign set_paddr = (res_cause_set == FLT_NONE)
                     ? {mem_rsp_data[VA_W-1:OFF_W], offset}
                     : '0;

    ptw_result #(
        .PA_W (VA_W)
    ) u_result (
        .clk       (clk),
        .rst       (rst),
        .set       (res_set),
        .set_cause (res_cause_set),
        .set_paddr (set_paddr),
        .ready     (res_ready),
        .valid     (res_valid),
        .paddr     (res_paddr),
        .cause     (cause_q)
    );

    assign res_cause = cause_q;
    assign res_fault = (cause_q != FLT_NONE);

    assign unused_entry_bits = ^mem_rsp_data[OFF_W-1:1];

    AST_RANGE_FAST: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && ({1'b0, req_vaddr[VA_W-1 -: OUTER_W]} >= cfg_len))
        |=> (res_valid && res_fault && res_cause == 2'd1)); // R5

    AST_OUTER_FAULT: assert property (@(posedge clk) disable iff (rst)
        (walk_state == ST_WT_OUTER && mem_rsp_valid && !mem_rsp_data[0])
        |=> (res_valid && res_cause == 2'd2 && !mem_req_valid)); // R6

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr)); // R10

endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] cfg_base = '0;
    logic [12:0] cfg_len = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic [31:0] res_paddr;
    logic        res_fault;
    logic [1:0]  res_cause;
    logic        busy;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] mem [logic [31:0]];

    always #2.5 clk = ~clk;

    pt_walker u_pt_walker (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .cfg_base      (cfg_base),
        .cfg_len       (cfg_len),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .res_valid     (res_valid),
        .res_ready     (res_ready),
        .res_paddr     (res_paddr),
        .res_fault     (res_fault),
        .res_cause     (res_cause),
        .busy          (busy)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Place an outer entry and an inner entry for va; junk in bits 9:1.
    task automatic map(input logic [31:0] va, input logic [21:0] ptr,
                       input logic [21:0] frame, input bit ov, input bit iv);
        logic [31:0] a0;
        logic [31:0] a1;
        a0 = cfg_base + {18'h0, va[31:20], 2'b00};
        a1 = {ptr, 10'h0} + {20'h0, va[19:10], 2'b00};
        mem[a0] = {ptr, 9'h155, ov};
        mem[a1] = {frame, 9'h1FF, iv};
    endtask

    task automatic run_walk(input string tag, input logic [31:0] va,
                            input int lat, input int stall, input int hold,
                            input bit poke, input bit scramble,
                            input logic [1:0] exp_cause, input logic [31:0] exp_paddr,
                            input int exp_reads, input int exp_edges);
        logic [31:0] base0;
        logic [31:0] a0;
        logic [31:0] a1;
        logic [31:0] rdata;
        logic [31:0] held;
        int cyc;
        int reads;
        int pend;
        int stall_left;
        bit hs;
        bit done;
        base0 = cfg_base;
        a0    = base0 + {18'h0, va[31:20], 2'b00};
        a1    = {rd(a0)[31:10], 10'h0} + {20'h0, va[19:10], 2'b00};
        rdata = '0;
        cyc = 0; reads = 0; pend = 0; hs = 0; done = 0;
        stall_left = stall;
        @(negedge clk);
        chk("R8", "req_ready before request", {31'h0, req_ready}, 32'h1);
        req_vaddr     = va;
        req_valid     = 1'b1;
        mem_req_ready = (stall == 0);
        @(negedge clk);
        if (poke) req_vaddr = ~va;
        else      req_valid = 1'b0;
        if (scramble) cfg_base = base0 ^ 32'h0F0F_0000;
        while (!done && cyc < 400) begin
            if (res_valid) begin
                done = 1;
            end else begin
                if (poke)
                    chk("R8", "not ready while busy", {30'h0, req_ready, busy}, 32'h1);
                mem_rsp_valid = 1'b0;
                if (hs) begin
                    mem_req_ready = (stall == 0);
                    stall_left    = stall;
                    hs            = 0;
                end
                if (pend > 0) begin
                    pend--;
                    if (pend == 0) begin
                        mem_rsp_valid = 1'b1;
                        mem_rsp_data  = rdata;
                    end
                end
                if (mem_req_valid) begin
                    chk("R10", "no read while response pending", pend, 0);
                    if (!mem_req_ready && stall_left > 0) begin
                        chk("R10", "address held in stall", mem_req_addr,
                            (reads == 0) ? a0 : a1);
                        stall_left--;
                    end else begin
                        mem_req_ready = 1'b1;
                        chk(scramble ? "R13" : ((reads == 0) ? "R2" : "R3"),
                            "read address", mem_req_addr, (reads == 0) ? a0 : a1);
                        rdata = rd(mem_req_addr);
                        reads++;
                        pend = lat;
                        hs   = 1;
                    end
                end
                @(negedge clk);
                cyc++;
            end
        end
        mem_rsp_valid = 1'b0;
        req_valid     = 1'b0;
        chk(tag, "result arrived", {31'h0, done}, 32'h1);
        chk("R11", "edges to result", cyc, exp_edges);
        chk(tag, "read count", reads, exp_reads);
        chk(tag, "cause", {30'h0, res_cause}, {30'h0, exp_cause});
        chk(tag, "fault flag", {31'h0, res_fault}, {31'h0, (exp_cause != 2'd0)});
        chk(tag, "paddr", res_paddr, exp_paddr);
        if (exp_cause == 2'd0)
            chk("R1", "offset carried", {22'h0, res_paddr[9:0]}, {22'h0, va[9:0]});
        held = res_paddr;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk("R9", "result held", {30'h0, res_valid, busy}, 32'h3);
            chk("R9", "paddr stable", res_paddr, held);
        end
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk("R9", "released after take", {29'h0, res_valid, req_ready, busy}, 32'h2);
        if (scramble) cfg_base = base0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12", "reset outputs",
            {28'h0, req_ready, busy, mem_req_valid, res_valid}, 32'h8);
        rst = 1'b0;
    endtask

    task automatic t_basic();
        logic [31:0] va;
        va = 32'h1234_5678;
        cfg_base = 32'h0004_0000;
        cfg_len  = 13'd4096;
        map(va, 22'h0A001, 22'h03ABC, 1'b1, 1'b1);
        run_walk("R4", va, 1, 0, 0, 0, 0, 2'd0, {22'h03ABC, va[9:0]}, 2, 4);
    endtask

    task automatic t_slow();
        logic [31:0] va;
        va = 32'h9ABC_DE01;
        map(va, 22'h0B002, 22'h1F00F, 1'b1, 1'b1);
        run_walk("R4", va, 3, 2, 3, 0, 0, 2'd0, {22'h1F00F, va[9:0]}, 2, 12);
    endtask

    task automatic t_range();
        logic [31:0] va;
        cfg_len = 13'h100;
        va = {12'h100, 10'h02A, 10'h155};
        run_walk("R5", va, 1, 0, 1, 0, 0, 2'd1, 32'h0, 0, 0);
        va = {12'h0FF, 10'h001, 10'h3FF};
        map(va, 22'h0C003, 22'h2AAAA, 1'b1, 1'b1);
        run_walk("R5", va, 1, 0, 0, 0, 0, 2'd0, {22'h2AAAA, va[9:0]}, 2, 4);
        cfg_len = 13'h0;
        va = 32'h0000_0400;
        run_walk("R5", va, 1, 0, 0, 0, 0, 2'd1, 32'h0, 0, 0);
        cfg_len = 13'd4096;
        va = 32'hFFFF_FFFF;
        map(va, 22'h0D004, 22'h3FFFF, 1'b1, 1'b1);
        run_walk("R5", va, 2, 1, 0, 0, 0, 2'd0, {22'h3FFFF, va[9:0]}, 2, 8);
    endtask

    task automatic t_outer_invalid();
        logic [31:0] va;
        va = {12'h456, 10'h111, 10'h222};
        map(va, 22'h0E005, 22'h11111, 1'b0, 1'b1);
        run_walk("R6", va, 2, 0, 2, 0, 0, 2'd2, 32'h0, 1, 3);
    endtask

    task automatic t_inner_invalid();
        logic [31:0] va;
        va = {12'h567, 10'h2F0, 10'h00F};
        map(va, 22'h0F006, 22'h22222, 1'b1, 1'b0);
        run_walk("R7", va, 1, 0, 0, 0, 0, 2'd3, 32'h0, 2, 4);
    endtask

    task automatic t_busy_poke();
        logic [31:0] va;
        va = {12'h777, 10'h0AB, 10'h0CD};
        map(va, 22'h10007, 22'h33333, 1'b1, 1'b1);
        run_walk("R8", va, 2, 0, 1, 1, 0, 2'd0, {22'h33333, va[9:0]}, 2, 6);
    endtask

    task automatic t_cfg_capture();
        logic [31:0] va;
        va = {12'h222, 10'h3C3, 10'h181};
        map(va, 22'h11008, 22'h04444, 1'b1, 1'b1);
        run_walk("R13", va, 1, 1, 0, 0, 1, 2'd0, {22'h04444, va[9:0]}, 2, 6);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_slow();
        t_range();
        t_outer_invalid();
        t_inner_invalid();
        t_busy_poke();
        t_cfg_capture();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule